// File: doc/BRIEF.md
# Command-Symbol Cell Receive Delineator

This block sits behind an external deserializer that hands over one 9-bit word on every clock, together with a flag that says whether the low eight bits carry a command symbol or a data octet. Bit 8 of the word is a line code-violation indication. The block recovers cell boundaries from the in-band start-of-cell command only. Once it has seen that command, it gathers the next 53 data octets into one cell and streams them out with start and end markers.

Sync commands are thrown away. Words that carry a violation are treated as though the clock had not ticked for the receiver: they neither move the state machine nor produce output. Each of them adds one to a saturating line-violation counter, which a clear strobe resets. If a command breaks into a cell before all 53 octets have arrived, the partial cell is flagged as aborted. A start-of-cell command that does this also opens a fresh cell at once.

Top module: `cmd_cell_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the receiver returns to hunting with no cell in progress. After that edge `rx_valid`, `rx_sop`, `rx_eop` and `rx_abort` are 0 and `viol_count` is 0.
- R2: While hunting, data octets, sync commands (code `SYNC_CODE`, default 0xC5) and any other non-start command produce no output, and the receiver keeps hunting.
- R3: A word is a data octet when `lw_cmd`=0 and bit 8 is 0. It is a command when `lw_cmd`=1 and bit 8 is 0, and bits 7:0 hold its code. After a start-of-cell command (code `SOC_CODE`, default 0x3A), each of the next 53 data octets appears on `rx_data` with `rx_valid`=1, one clock after its input word.
- R4: `rx_sop` is 1 only with octet 0 of a cell and `rx_eop` is 1 only with octet 52. After octet 52 the receiver hunts again, so further data octets are dropped.
- R5: A word with bit 8 set is a violation, whatever `lw_cmd` says. It changes no receiver state and produces no `rx_valid` or `rx_abort`. A cell that a violation interrupts continues with the next octet.
- R6: Each violation word raises `viol_count` by one, visible one clock later.
- R7: `viol_count` is 16 bits wide and holds at 65535 when more violations arrive.
- R8: When `viol_clr`=1 at a clock edge, `viol_count` becomes 0 after that edge. A violation in the same cycle is not counted.
- R9: A command other than start-of-cell that arrives after at least one octet of a cell has been taken pulses `rx_abort` for one cycle, with `rx_valid`=0. The receiver then returns to hunting.
- R10: A start-of-cell command that arrives after at least one octet of a cell pulses `rx_abort`. The next data octet becomes octet 0 of a new cell.
- R11: Between a start-of-cell command and the first octet, a sync command is discarded and the cell stays open. A further start-of-cell command keeps it open. Any other command returns the receiver to hunting. None of these raises `rx_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lw_word | input | 9 | Bit 8 marks a violation; bits 7:0 hold a data octet or a command code |
| lw_cmd | input | 1 | 1 when bits 7:0 of `lw_word` hold a command code |
| viol_clr | input | 1 | Clear strobe for the violation counter |
| rx_valid | output | 1 | Data octet valid |
| rx_data | output | 8 | Cell octet |
| rx_sop | output | 1 | First octet of a cell |
| rx_eop | output | 1 | Last octet of a cell |
| rx_abort | output | 1 | One-cycle pulse when a command cuts a partial cell short |
| viol_count | output | 16 | Saturating count of violation words |

## Verification
On every cycle the assertions check the counter's arithmetic: increment, hold at saturation and clear priority. They also check that a violation word leaves the stream quiet, that a data octet taken while hunting emits nothing, and that an abort pulse never coincides with a valid octet. Whether the 53-octet count is right, and whether an abort or a restarted cell begins at the proper octet, depends on a history of many words. Only the bench's scenarios can show that, by comparing each output with a behavioural model through full cells, interrupted cells, interleaved violations and command sequences in the gap after start-of-cell.

// File: rtl/cmd_cell_rx.sv
module cmd_cell_rx #(
  parameter int          CELL_LEN  = 53,
  parameter int          CNT_W     = 16,
  parameter logic [7:0]  SYNC_CODE = 8'hC5,
  parameter logic [7:0]  SOC_CODE  = 8'h3A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [8:0]       lw_word,
  input  logic             lw_cmd,
  input  logic             viol_clr,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_sop,
  output logic             rx_eop,
  output logic             rx_abort,
  output logic [CNT_W-1:0] viol_count
);
  localparam int               IDX_W   = $clog2(CELL_LEN + 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(CELL_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_cell;
  logic [IDX_W-1:0] idx;

  wire       viol      = lw_word[8];
  wire [7:0] code      = lw_word[7:0];
  wire       take_data = !viol && !lw_cmd && in_cell;
  wire       take_cmd  = !viol && lw_cmd;
  wire       partial   = in_cell && (idx != '0);
  wire       is_soc    = (code == SOC_CODE);
  wire       keep_open = in_cell && !partial && (code == SYNC_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cell  <= 1'b0;
      idx      <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_sop   <= 1'b0;
      rx_eop   <= 1'b0;
      rx_abort <= 1'b0;
    end else begin
      rx_valid <= take_data;
      rx_sop   <= take_data && (idx == '0);
      rx_eop   <= take_data && (idx == LAST);
      rx_abort <= take_cmd && partial;
      if (take_data) rx_data <= code;
      if (take_data) begin
        if (idx == LAST) begin
          in_cell <= 1'b0;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (take_cmd) begin
        if (is_soc) begin
          in_cell <= 1'b1;
          idx     <= '0;
        end else if (!keep_open) begin
          in_cell <= 1'b0;
          idx     <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || viol_clr)                 viol_count <= '0;
    else if (viol && viol_count != CNT_MAX) viol_count <= viol_count + 1'b1;
  end
endmodule

module cmd_cell_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [8:0]       lw_word,
  input logic             lw_cmd,
  input logic             viol_clr,
  input logic             rx_valid,
  input logic             rx_eop,
  input logic             rx_abort,
  input logic [CNT_W-1:0] viol_count,
  input logic             in_cell
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_abort && viol_count == '0));

  // R2
  hunt_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_cell && !lw_word[8] && !lw_cmd) |=> !rx_valid);

  // R4
  eop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    rx_eop |-> (rx_valid && !in_cell));

  // R5
  viol_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lw_word[8] |=> (!rx_valid && !rx_abort));

  // R6
  viol_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (lw_word[8] && !viol_clr && viol_count != CNT_MAX)
      |=> viol_count == CNT_W'($past(viol_count) + 1'b1));

  // R7
  viol_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_count == CNT_MAX && !viol_clr) |=> viol_count == CNT_MAX);

  // R8
  viol_clr_chk: assert property (@(posedge clk) disable iff (rst)
    viol_clr |=> viol_count == '0);

  // R9
  abort_alone_chk: assert property (@(posedge clk) disable iff (rst)
    rx_abort |-> !rx_valid);

  // R5
  viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lw_word[8] && !lw_cmd) |=> in_cell == $past(in_cell));
endmodule

bind cmd_cell_rx cmd_cell_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lw_word(lw_word), .lw_cmd(lw_cmd),
  .viol_clr(viol_clr), .rx_valid(rx_valid), .rx_eop(rx_eop),
  .rx_abort(rx_abort), .viol_count(viol_count), .in_cell(in_cell)
);

// File: tb/cmd_cell_rx_bench.sv
module cmd_cell_rx_bench;
  localparam logic [7:0] SYNC  = 8'hC5;
  localparam logic [7:0] SOC   = 8'h3A;
  localparam logic [7:0] OTHER = 8'h55;
  localparam int         MAXC  = 65535;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [8:0]  lw_word = '0;
  logic        lw_cmd = 1'b0;
  logic        viol_clr = 1'b0;
  logic        rx_valid, rx_sop, rx_eop, rx_abort;
  logic [7:0]  rx_data;
  logic [15:0] viol_count;

  int checks = 0;
  int errors = 0;
  int m_in = 0, m_idx = 0, m_cnt = 0;
  int e_valid = 0, e_sop = 0, e_eop = 0, e_abort = 0, e_data = 0;

  cmd_cell_rx u_cmd_cell_rx (
    .clk(clk), .rst(rst), .lw_word(lw_word), .lw_cmd(lw_cmd),
    .viol_clr(viol_clr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_abort(rx_abort),
    .viol_count(viol_count)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "rx_valid", int'(rx_valid), e_valid);
    if (e_valid != 0) chk(req, "rx_data", int'(rx_data), e_data);
    chk(req, "rx_sop", int'(rx_sop), e_sop);
    chk(req, "rx_eop", int'(rx_eop), e_eop);
    chk(req, "rx_abort", int'(rx_abort), e_abort);
    chk(req, "viol_count", int'(viol_count), m_cnt);
  endtask

  task automatic step(bit cmd, bit v, logic [7:0] b, bit clr, string req);
    @(negedge clk);
    lw_cmd = cmd; lw_word = {v, b}; viol_clr = clr;
    e_valid = 0; e_sop = 0; e_eop = 0; e_abort = 0;
    if (clr) m_cnt = 0;
    else if (v && m_cnt < MAXC) m_cnt++;
    if (!v) begin
      if (cmd) begin
        if (m_in != 0 && m_idx > 0) e_abort = 1;
        if (b == SOC) begin m_in = 1; m_idx = 0; end
        else if (m_in != 0 && m_idx == 0 && b == SYNC) begin end
        else begin m_in = 0; m_idx = 0; end
      end else if (m_in != 0) begin
        e_valid = 1; e_data = int'(b);
        e_sop = (m_idx == 0); e_eop = (m_idx == 52);
        m_idx++;
        if (m_idx == 53) begin m_in = 0; m_idx = 0; end
      end
    end
    @(posedge clk); #1;
    compare(req);
  endtask

  task automatic dat(logic [7:0] b, string req); step(0, 0, b, 0, req); endtask
  task automatic cmd(logic [7:0] b, string req); step(1, 0, b, 0, req); endtask
  task automatic vio(string req); step(0, 1, 8'hA5, 0, req); endtask

  task automatic octets(int n, int seed, string req);
    for (int i = 0; i < n; i++) dat(8'((i * 7 + seed) & 255), req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lw_word = '0; lw_cmd = 1'b0; viol_clr = 1'b0;
    @(posedge clk); #1;
    m_in = 0; m_idx = 0; m_cnt = 0;
    e_valid = 0; e_sop = 0; e_eop = 0; e_abort = 0;
    compare("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R2: hunting ignores data, sync and unknown commands
    octets(5, 1, "R2");
    cmd(SYNC, "R2"); cmd(OTHER, "R2"); octets(3, 9, "R2");
    // R3, R4: full cell then trailing data dropped
    cmd(SOC, "R3");
    octets(53, 3, "R3");
    octets(4, 11, "R4");
    // R5, R6: violations interleaved in a cell
    cmd(SOC, "R5");
    for (int i = 0; i < 53; i++) begin
      if (i % 9 == 4) begin vio("R5"); vio("R6"); end
      dat(8'(i + 100), "R5");
    end
    step(1, 1, SOC, 0, "R5");
    dat(8'h01, "R5");
    // R9: sync mid-cell aborts, then hunting
    cmd(SOC, "R9"); octets(10, 5, "R9"); cmd(SYNC, "R9"); octets(3, 2, "R9");
    cmd(SOC, "R9"); octets(1, 6, "R9"); cmd(OTHER, "R9"); dat(8'h44, "R9");
    // R10: start-of-cell mid-cell restarts
    cmd(SOC, "R10"); octets(20, 8, "R10"); cmd(SOC, "R10"); octets(53, 13, "R10");
    // R11: commands in the gap after start-of-cell
    cmd(SOC, "R11"); cmd(SYNC, "R11"); cmd(SYNC, "R11"); cmd(SOC, "R11");
    octets(53, 21, "R11");
    cmd(SOC, "R11"); cmd(OTHER, "R11"); octets(2, 4, "R11");
    // R1: reset mid-cell
    cmd(SOC, "R1"); octets(7, 2, "R1");
    do_reset();
    octets(2, 3, "R1");
    // R8: clear beats a coincident violation
    vio("R6"); vio("R6"); vio("R6");
    step(0, 1, 8'h00, 1, "R8");
    vio("R8");
    // R7: saturation
    for (int i = 0; i < MAXC + 4; i++) vio("R7");
    chk("R7", "saturated", int'(viol_count), MAXC);
    step(0, 0, 8'h00, 1, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule